// File: doc/BRIEF.md
# Decade Pulse Counter with Seven-Segment Drive

This block counts rising clock edges as pulses, keeps one decimal digit (0 to 9) and drives a seven-segment display directly from that digit. A carry output pulses low once per decade, so several blocks can be chained into a multi-digit counter. The carry of one stage feeds the clock of the next, or a synchronous enable built from it.

The display lines can be blanked with a display enable. This saves power without disturbing the count. An ungated copy of segment C stays live while the display is dark; it is low only on digit 2, which external logic can use for divide-by-twelve arrangements. A display-enable output repeats the display-enable input so the enable can be daisy-chained along a row of digits.

All pins are plain level signals. No data stream crosses the boundary, so no valid/ready handshake applies and there is no back-pressure.

Top module: `pulse_counter_7seg`

## Requirements
- R1: On each rising clock edge with `rst` low and `inhibit_i` low, the digit advances by one, from 0 up to 9.
- R2: While `inhibit_i` is high (and `rst` low), rising edges leave the digit unchanged.
- R3: A counting edge taken while the digit is 9 returns the digit to 0.
- R4: `carry_n_o` is low for exactly one clock period, the period that starts with the 9-to-0 edge. It is high at all other times, including after reset.
- R5: `rst` is active high and synchronous. At the next rising edge it sets the digit to 0 and `carry_n_o` high, and it overrides `inhibit_i`.
- R6: `seg_o` is active high (common cathode). Bit 0 is segment a and bit 6 is segment g. With the display enabled, digits 0 to 9 give hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R7: While `disp_en_i` is low, `seg_o` is all zeros, in the same cycle, and the count is unaffected.
- R8: `seg_c_raw_o` equals segment c (bit 2 of the R6 code) of the current digit, whatever the level of `disp_en_i`.
- R9: `disp_en_o` equals `disp_en_i` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its rising edges are the counted pulses |
| rst | input | 1 | Synchronous master reset, active high |
| disp_en_i | input | 1 | Display enable, active high |
| inhibit_i | input | 1 | Count hold, active high |
| seg_o | output | 7 | Segment lines a (bit 0) through g (bit 6), gated by the display enable |
| seg_c_raw_o | output | 1 | Ungated segment c |
| carry_n_o | output | 1 | Decade carry, active low, one clock long |
| disp_en_o | output | 1 | Copy of the display enable |

## Verification
The digit and the carry are registered, so each is due one rising edge after the stimulus that causes it. The segment lines, the ungated segment c and the enable copy are combinational: they follow the digit in that same cycle and follow `disp_en_i` with no edge at all. The bench changes inputs on the falling edge and checks registered results at the next falling edge, exactly one rising edge later. After a change of `disp_en_i` it checks the combinational outputs after a short settling delay, with no clock edge in between.

// File: rtl/pc7_pkg.sv
`timescale 1ns/1ps
package pc7_pkg;

  localparam int SEG_N = 7;

  typedef logic [SEG_N-1:0] seg_t;

  // Active-high segment code for one decimal digit; bit 0 = a ... bit 6 = g.
  function automatic seg_t digit_to_seg(input logic [3:0] d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b011_1111;
      4'd1:    s = 7'b000_0110;
      4'd2:    s = 7'b101_1011;
      4'd3:    s = 7'b100_1111;
      4'd4:    s = 7'b110_0110;
      4'd5:    s = 7'b110_1101;
      4'd6:    s = 7'b111_1101;
      4'd7:    s = 7'b000_0111;
      4'd8:    s = 7'b111_1111;
      4'd9:    s = 7'b110_1111;
      default: s = 7'b000_0000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pc7_counter.sv
`timescale 1ns/1ps
module pc7_counter #(
  parameter int MODULUS = 10,
  localparam int CNT_W = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [CNT_W-1:0] digit,
  output logic             carry_n
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  logic [CNT_W-1:0] digit_q;
  logic             carry_n_q;
  logic             at_last;

  assign at_last = (digit_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_q   <= '0;
      carry_n_q <= 1'b1;
    end else if (hold) begin
      carry_n_q <= 1'b1;
    end else begin
      digit_q   <= at_last ? '0 : digit_q + 1'b1;
      carry_n_q <= ~at_last;
    end
  end

  assign digit   = digit_q;
  assign carry_n = carry_n_q;

endmodule

// File: rtl/pc7_seg_decode.sv
`timescale 1ns/1ps
module pc7_seg_decode
  import pc7_pkg::*;
#(
  parameter int  DIGIT_W      = 4,
  parameter bit  COMMON_ANODE = 1'b0
) (
  input  logic [DIGIT_W-1:0] digit,
  output seg_t               seg
);

  seg_t raw;

  assign raw = digit_to_seg(4'(digit));

  generate
    if (COMMON_ANODE) begin : g_low
      assign seg = ~raw;
    end else begin : g_high
      assign seg = raw;
    end
  endgenerate

endmodule

// File: rtl/pc7_blanker.sv
`timescale 1ns/1ps
module pc7_blanker
  import pc7_pkg::*;
#(
  parameter bit COMMON_ANODE = 1'b0
) (
  input  logic en,
  input  seg_t seg_in,
  output seg_t seg_out
);

  localparam seg_t DARK = COMMON_ANODE ? {SEG_N{1'b1}} : {SEG_N{1'b0}};

  assign seg_out = en ? seg_in : DARK;

endmodule

// File: rtl/pulse_counter_7seg.sv
`timescale 1ns/1ps
module pulse_counter_7seg
  import pc7_pkg::*;
#(
  parameter int MODULUS = 10,
  localparam int CNT_W = $clog2(MODULUS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       disp_en_i,
  input  logic       inhibit_i,
  output logic [6:0] seg_o,
  output logic       seg_c_raw_o,
  output logic       carry_n_o,
  output logic       disp_en_o
);

  localparam int SEG_C = 2;

  logic [CNT_W-1:0] cnt_q;
  seg_t             seg_raw;

  pc7_counter #(.MODULUS(MODULUS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .hold    (inhibit_i),
    .digit   (cnt_q),
    .carry_n (carry_n_o)
  );

  pc7_seg_decode #(.DIGIT_W(CNT_W), .COMMON_ANODE(1'b0)) u_dec (
    .digit (cnt_q),
    .seg   (seg_raw)
  );

  pc7_blanker #(.COMMON_ANODE(1'b0)) u_blank (
    .en      (disp_en_i),
    .seg_in  (seg_raw),
    .seg_out (seg_o)
  );

  assign seg_c_raw_o = seg_raw[SEG_C];
  assign disp_en_o   = disp_en_i;

endmodule

// File: rtl/pc7_checker.sv
`timescale 1ns/1ps
module pc7_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_en_i,
  input logic             inhibit_i,
  input logic [CNT_W-1:0] cnt,
  input logic [6:0]       seg_o,
  input logic             seg_c_raw_o,
  input logic             carry_n_o,
  input logic             disp_en_o
);

  localparam logic [CNT_W-1:0] NINE = CNT_W'(9);

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!inhibit_i && cnt != NINE) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |=> $stable(cnt));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!inhibit_i && cnt == NINE) |=> (cnt == '0));

  p_carry_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!inhibit_i && cnt == NINE) |=> !carry_n_o);

  p_carry_one_r4: assert property (@(posedge clk) disable iff (rst)
    !carry_n_o |=> carry_n_o);

  p_clear_r5: assert property (@(posedge clk)
    rst |=> (cnt == '0 && carry_n_o));

  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !disp_en_i |-> (seg_o == 7'd0));

  p_rawc_r8: assert property (@(posedge clk) disable iff (rst)
    disp_en_i |-> (seg_c_raw_o == seg_o[2]));

  p_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    disp_en_o == disp_en_i);

endmodule

bind pulse_counter_7seg pc7_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .disp_en_i   (disp_en_i),
  .inhibit_i   (inhibit_i),
  .cnt         (cnt_q),
  .seg_o       (seg_o),
  .seg_c_raw_o (seg_c_raw_o),
  .carry_n_o   (carry_n_o),
  .disp_en_o   (disp_en_o)
);

// File: tb/pulse_counter_7seg_test.sv
`timescale 1ns/1ps
module pulse_counter_7seg_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       den = 1'b1;
  logic       inh = 1'b0;
  logic [6:0] seg;
  logic       segc, carry_n, den_o;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;
  int exp_d  = 0;

  always #2.5 clk = ~clk;

  pulse_counter_7seg uut (
    .clk(clk), .rst(rst), .disp_en_i(den), .inhibit_i(inh),
    .seg_o(seg), .seg_c_raw_o(segc), .carry_n_o(carry_n), .disp_en_o(den_o)
  );

  // Spec table from R6: bit0 = a ... bit6 = g, active high.
  function automatic logic [6:0] spec_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic t_reset;
    rst = 1'b1; inh = 1'b0; den = 1'b1;
    step(2);
    rst = 1'b0;
    chk("R5 digit after reset", seg, spec_seg(0));
    chk("R5 carry after reset", carry_n, 1'b1);
    exp_d = 0;
  endtask

  task automatic t_count_up;
    for (int k = 1; k <= 9; k++) begin
      step(1);
      exp_d = k;
      chk("R1 count step", seg, spec_seg(exp_d));
      chk("R6 segment code", seg, spec_seg(k));
      chk("R8 raw c enabled", segc, spec_seg(k) >> 2 & 1);
      chk("R4 carry high mid-decade", carry_n, 1'b1);
    end
  endtask

  task automatic t_wrap_carry;
    step(1);
    exp_d = 0;
    chk("R3 wrap to zero", seg, spec_seg(0));
    chk("R4 carry low on wrap", carry_n, 1'b0);
    step(1);
    exp_d = 1;
    chk("R4 carry one period", carry_n, 1'b1);
    chk("R1 count after wrap", seg, spec_seg(1));
  endtask

  task automatic t_inhibit;
    step(2);
    exp_d = 3;
    chk("R1 reach three", seg, spec_seg(3));
    inh = 1'b1;
    step(4);
    chk("R2 hold digit", seg, spec_seg(3));
    inh = 1'b0;
    step(6);
    exp_d = 9;
    chk("R1 reach nine", seg, spec_seg(9));
    inh = 1'b1;
    step(2);
    chk("R2 hold at nine", seg, spec_seg(9));
    chk("R4 no carry while held", carry_n, 1'b1);
    inh = 1'b0;
    step(1);
    exp_d = 0;
    chk("R3 wrap after hold", seg, spec_seg(0));
    chk("R4 carry after hold", carry_n, 1'b0);
  endtask

  task automatic t_blank;
    den = 1'b0;
    #1;
    chk("R7 blank immediate", seg, 7'h00);
    chk("R9 mirror low", den_o, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      step(1);
      chk("R7 blanked", seg, 7'h00);
      chk("R8 raw c blanked", segc, spec_seg(k) >> 2 & 1);
    end
    exp_d = 9;
    den = 1'b1;
    #1;
    chk("R7 count kept while blank", seg, spec_seg(9));
    chk("R9 mirror high", den_o, 1'b1);
  endtask

  task automatic t_reset_priority;
    step(3);
    exp_d = 2;
    chk("R1 count before reset", seg, spec_seg(2));
    chk("R8 raw c on two", segc, 1'b0);
    rst = 1'b1; inh = 1'b1;
    step(1);
    chk("R5 reset over inhibit", seg, spec_seg(0));
    chk("R5 carry high in reset", carry_n, 1'b1);
    rst = 1'b0; inh = 1'b0;
    step(1);
    chk("R1 count after reset", seg, spec_seg(1));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count_up();
    t_wrap_carry();
    t_inhibit();
    t_blank();
    t_reset_priority();
    done = 1;
    summary();
    $finish;
  end

endmodule